// File: doc/BRIEF.md
# Clocked Serial Receive Channel

This block is one receive lane of a clocked serial link. It runs on the system clock and watches a slower peripheral clock as a plain input. Once the lane is enabled it waits for a start bit of selectable polarity. After the start bit it samples the data line on every rising peripheral-clock edge, shifting each bit into the low end of an 8-bit shadow register. When a programmable number of bits has arrived, it hands a parallel word and a valid flag to the host. Reception then carries on as a continuous stream with no further start bits.

The host must take each word and drop the valid flag within one data frame, measured in peripheral-clock edges by a 12-bit frame length. If valid is held past that window, a sticky overflow flag is raised. The lane can be enabled by a host write. It can also arm itself at the end of a transmit operation, spending one count from a 16-bit arm budget each time it does so. A host write of zero to the enable returns the lane to its idle, cleared state.

Top module: `ssr_rx_chan`

## Requirements
- R1: After reset, rx_data is 0, rx_valid is 0, rx_ovf is 0 and rx_enabled is 0.
- R2: While the lane is disabled, or before a start bit is seen, rising peripheral-clock edges change no output. A start bit is a rising edge at which sdi equals start_pol (1 means a high start bit, 0 means a low one). The start bit itself is not part of the data.
- R3: Each rising peripheral-clock edge after the start bit shifts sdi into bit 0 of the shadow register and moves earlier bits toward bit 7. A completed word of N bits appears on rx_data with the first received bit at position N-1, and with bits N to 7 forced to 0.
- R4: sample_code selects N. Code 0 means 8 bits, and codes 1 to 7 mean that many bits. rx_valid rises in the cycle after the edge that delivers the Nth bit. Words then follow back to back without another start bit.
- R5: rx_data changes only when a word completes or when the lane is disabled.
- R6: A one-cycle vld_clr pulse makes rx_valid 0 in the next cycle. If a word completes on that same cycle, rx_valid stays 1 and rx_data takes the new word.
- R7: Count the rising peripheral-clock edges seen while rx_valid is already 1 without an intervening clear. rx_ovf becomes 1 at the edge where this count would exceed frame_len. rx_ovf then stays 1 until the lane is disabled, whatever vld_clr does.
- R8: With auto_mode at 1, a tx_done pulse while the lane is disabled and the arm count is nonzero enables the lane and lowers the count by 1. With the count at 0, tx_done leaves the lane disabled.
- R9: An arm_load pulse sets the arm count to arm_value.
- R10: A write (en_we with en_wdata 0) disables the lane. It clears rx_data, rx_valid and rx_ovf and returns the lane to waiting for a start bit once it is re-enabled.
- R11: A write (en_we with en_wdata 1) enables the lane, shown on rx_enabled in the next cycle. A write in the same cycle as tx_done takes priority over automatic arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Host write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| auto_mode | input | 1 | Allow self-arming after transmit |
| tx_done | input | 1 | One-cycle pulse at the end of a transmit operation |
| arm_load | input | 1 | Load strobe for the arm count |
| arm_value | input | ARM_W | Arm count load value |
| start_pol | input | 1 | Active level of the start bit |
| sample_code | input | 3 | Bits per word (0 means 8) |
| frame_len | input | FRAME_W | Data frame length in peripheral-clock edges |
| pclk | input | 1 | Peripheral clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| vld_clr | input | 1 | Host pulse that clears rx_valid |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | A word is waiting for the host |
| rx_ovf | output | 1 | Sticky overflow flag |
| rx_enabled | output | 1 | Lane enable state |

## Verification
The bench attacks several corner cases, each of which a faulty design would show at the ports:
- **Start bit.** Data-level bits sent before the start bit are a trap: a lane that starts shifting too early would present a word offset by those bits.
- **Short word sizes.** A lane that fails to mask the upper bits would leak stale shadow bits into rx_data.
- **Clear in the same cycle as a word.** A lane that lets the clear win would drop a valid word.
- **Overflow.** Frame lengths are held short so that an off-by-one in the frame window sets rx_ovf one edge early or one edge late. The bench then clears valid to prove the flag is sticky.
- **Arm budget.** Auto-arming is driven past the budget, so a lane that keeps arming at zero, or wraps the count, is caught.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int SHADOW_W = 8;
    localparam int CODE_W   = 3;
    localparam int CNT_W    = $clog2(SHADOW_W + 1);

    typedef enum logic [1:0] {
        RX_OFF,
        RX_HUNT,
        RX_SHIFT
    } rx_state_e;

    typedef struct packed {
        logic              start_pol;
        logic [CODE_W-1:0] code;
    } rx_cfg_t;

    // bits per word: code 0 selects a full shadow register
    function automatic logic [CNT_W-1:0] word_len(input logic [CODE_W-1:0] code);
        if (code == '0) begin
            return CNT_W'(SHADOW_W);
        end
        return CNT_W'(code);
    endfunction

    // ones in the low n positions
    function automatic logic [SHADOW_W-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [SHADOW_W-1:0] m;
        for (int i = 0; i < SHADOW_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/ssr_pclk_edge.sv
module ssr_pclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic pclk,
    output logic rise
);
    logic pclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q <= 1'b0;
        end else begin
            pclk_q <= pclk;
        end
    end

    assign rise = pclk & ~pclk_q;
endmodule

// File: rtl/ssr_arm_ctrl.sv
module ssr_arm_ctrl #(
    parameter int ARM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             auto_mode,
    input  logic             tx_done,
    input  logic             arm_load,
    input  logic [ARM_W-1:0] arm_value,
    output logic             en_q,
    output logic [ARM_W-1:0] arm_cnt,
    output logic             dis_pulse
);
    logic arm_fire;

    assign arm_fire  = auto_mode & tx_done & ~en_q & ~en_we & (arm_cnt != '0);
    assign dis_pulse = en_we & ~en_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (en_we) begin
            en_q <= en_wdata;
        end else if (arm_fire) begin
            en_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_cnt <= '0;
        end else if (arm_load) begin
            arm_cnt <= arm_value;
        end else if (arm_fire) begin
            arm_cnt <= arm_cnt - ARM_W'(1);
        end
    end
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                en,
    input  logic                rise,
    input  logic                sdi,
    input  rx_cfg_t             cfg,
    output logic                word_done,
    output logic [SHADOW_W-1:0] word
);
    rx_state_e           state;
    logic [SHADOW_W-1:0] shadow;
    logic [SHADOW_W-1:0] shadow_nx;
    logic [CNT_W-1:0]    bitcnt;
    logic [CNT_W-1:0]    bitcnt_nx;
    logic [CNT_W-1:0]    need;

    assign need      = word_len(cfg.code);
    assign shadow_nx = {shadow[SHADOW_W-2:0], sdi};
    assign bitcnt_nx = bitcnt + CNT_W'(1);
    assign word_done = (state == RX_SHIFT) && rise && (bitcnt_nx >= need);
    assign word      = shadow_nx & low_mask(need);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state  <= RX_OFF;
            shadow <= '0;
            bitcnt <= '0;
        end else if (!en) begin
            state  <= RX_OFF;
        end else begin
            unique case (state)
                RX_OFF: begin
                    state <= RX_HUNT;
                end
                RX_HUNT: begin
                    if (rise && (sdi == cfg.start_pol)) begin
                        state  <= RX_SHIFT;
                        shadow <= '0;
                        bitcnt <= '0;
                    end
                end
                RX_SHIFT: begin
                    if (rise) begin
                        shadow <= shadow_nx;
                        bitcnt <= word_done ? '0 : bitcnt_nx;
                    end
                end
                default: state <= RX_OFF;
            endcase
        end
    end
endmodule

// File: rtl/ssr_hold_mon.sv
module ssr_hold_mon
    import ssr_pkg::*;
#(
    parameter int FRAME_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                rise,
    input  logic                word_done,
    input  logic [SHADOW_W-1:0] word,
    input  logic                vld_clr,
    input  logic [FRAME_W-1:0]  frame_len,
    output logic [SHADOW_W-1:0] data,
    output logic                valid,
    output logic                ovf
);
    logic [FRAME_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            data  <= '0;
            valid <= 1'b0;
        end else if (word_done) begin
            data  <= word;
            valid <= 1'b1;
        end else if (vld_clr) begin
            valid <= 1'b0;
        end
    end

    // age of the held word, in peripheral edges
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            age <= '0;
            ovf <= 1'b0;
        end else if (vld_clr || !valid) begin
            age <= '0;
        end else if (rise) begin
            if (age == frame_len) begin
                ovf <= 1'b1;
            end else begin
                age <= age + FRAME_W'(1);
            end
        end
    end
endmodule

// File: rtl/ssr_rx_chan.sv
module ssr_rx_chan
    import ssr_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int ARM_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_we,
    input  logic                en_wdata,
    input  logic                auto_mode,
    input  logic                tx_done,
    input  logic                arm_load,
    input  logic [ARM_W-1:0]    arm_value,
    input  logic                start_pol,
    input  logic [CODE_W-1:0]   sample_code,
    input  logic [FRAME_W-1:0]  frame_len,
    input  logic                pclk,
    input  logic                sdi,
    input  logic                vld_clr,
    output logic [SHADOW_W-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_ovf,
    output logic                rx_enabled
);
    logic                rise;
    logic                en_q;
    logic [ARM_W-1:0]    arm_cnt;
    logic                dis_pulse;
    logic                word_done;
    logic [SHADOW_W-1:0] word;
    rx_cfg_t             cfg;

    assign cfg        = '{start_pol: start_pol, code: sample_code};
    assign rx_enabled = en_q;

    ssr_pclk_edge u_edge (
        .clk (clk),
        .rst (rst),
        .pclk(pclk),
        .rise(rise)
    );

    ssr_arm_ctrl #(.ARM_W(ARM_W)) u_arm (
        .clk      (clk),
        .rst      (rst),
        .en_we    (en_we),
        .en_wdata (en_wdata),
        .auto_mode(auto_mode),
        .tx_done  (tx_done),
        .arm_load (arm_load),
        .arm_value(arm_value),
        .en_q     (en_q),
        .arm_cnt  (arm_cnt),
        .dis_pulse(dis_pulse)
    );

    ssr_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .flush    (dis_pulse),
        .en       (en_q),
        .rise     (rise),
        .sdi      (sdi),
        .cfg      (cfg),
        .word_done(word_done),
        .word     (word)
    );

    ssr_hold_mon #(.FRAME_W(FRAME_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .flush    (dis_pulse),
        .rise     (rise),
        .word_done(word_done),
        .word     (word),
        .vld_clr  (vld_clr),
        .frame_len(frame_len),
        .data     (rx_data),
        .valid    (rx_valid),
        .ovf      (rx_ovf)
    );
endmodule

// File: rtl/ssr_rx_chan_chk.sv
module ssr_rx_chan_chk #(
    parameter int ARM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_we,
    input logic             auto_mode,
    input logic             tx_done,
    input logic             vld_clr,
    input logic [7:0]       rx_data,
    input logic             rx_valid,
    input logic             rx_ovf,
    input logic             rx_enabled,
    input logic             word_done,
    input logic             dis_pulse,
    input logic [ARM_W-1:0] arm_cnt
);
    p_valid_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_enabled);

    p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!word_done && !dis_pulse) |=> $stable(rx_data));

    p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
        (vld_clr && !word_done && !dis_pulse) |=> !rx_valid);

    p_word_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (word_done && !dis_pulse) |=> rx_valid);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf && !dis_pulse) |=> rx_ovf);

    p_ovf_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovf) |-> $past(rx_valid));

    p_auto_arm_r8: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && tx_done && !en_we && !rx_enabled && arm_cnt != '0) |=> rx_enabled);
endmodule

bind ssr_rx_chan ssr_rx_chan_chk #(.ARM_W(ARM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_we     (en_we),
    .auto_mode (auto_mode),
    .tx_done   (tx_done),
    .vld_clr   (vld_clr),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ovf    (rx_ovf),
    .rx_enabled(rx_enabled),
    .word_done (word_done),
    .dis_pulse (dis_pulse),
    .arm_cnt   (arm_cnt)
);

// File: tb/sim_ssr_rx_chan.sv
module sim_ssr_rx_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_we = 1'b0, en_wdata = 1'b0, auto_mode = 1'b0, tx_done = 1'b0;
    logic        arm_load = 1'b0;
    logic [15:0] arm_value = '0;
    logic        start_pol = 1'b1;
    logic [2:0]  sample_code = '0;
    logic [11:0] frame_len = 12'd20;
    logic        pclk = 1'b0, sdi = 1'b0, vld_clr = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_ovf, rx_enabled;

    int checks = 0;
    int errors = 0;

    // bench reference state
    bit       m_en, m_hunt, m_shift, m_valid, m_ovf;
    bit [7:0] m_sh, m_data;
    int       m_cnt, m_age, m_arm;

    always #10 clk = ~clk;

    ssr_rx_chan u0 (
        .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
        .auto_mode(auto_mode), .tx_done(tx_done), .arm_load(arm_load),
        .arm_value(arm_value), .start_pol(start_pol), .sample_code(sample_code),
        .frame_len(frame_len), .pclk(pclk), .sdi(sdi), .vld_clr(vld_clr),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ovf(rx_ovf), .rx_enabled(rx_enabled)
    );

    function automatic int bits_for(input bit [2:0] code);
        return (code == 0) ? 8 : int'(code);
    endfunction

    function automatic bit [7:0] keep_low(input bit [7:0] v, input int n);
        return v & (8'hFF >> (8 - n));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "rx_data", int'(rx_data), int'(m_data));
        chk(req, "rx_valid", int'(rx_valid), int'(m_valid));
        chk(req, "rx_ovf", int'(rx_ovf), int'(m_ovf));
        chk(req, "rx_enabled", int'(rx_enabled), int'(m_en));
    endtask

    task automatic model_flush();
        m_en = 0; m_hunt = 0; m_shift = 0; m_valid = 0; m_ovf = 0;
        m_sh = 0; m_data = 0; m_cnt = 0; m_age = 0;
    endtask

    // one peripheral clock bit, optionally with a host clear on the same cycle
    task automatic send_bit(input bit b, input bit clr, input string req);
        bit old_v;
        bit done;
        @(negedge clk);
        sdi = b; pclk = 1'b1; vld_clr = clr;
        old_v = m_valid;
        done = 0;
        if (m_shift) begin
            m_sh = {m_sh[6:0], b};
            m_cnt++;
            if (m_cnt >= bits_for(sample_code)) begin
                done = 1;
                m_cnt = 0;
                m_data = keep_low(m_sh, bits_for(sample_code));
            end
        end else if (m_hunt && b == start_pol) begin
            m_shift = 1; m_hunt = 0; m_sh = 0; m_cnt = 0;
        end
        if (done) m_valid = 1;
        else if (clr) m_valid = 0;
        if (clr || !old_v) m_age = 0;
        else if (m_age == int'(frame_len)) m_ovf = 1;
        else m_age++;
        @(negedge clk);
        pclk = 1'b0; vld_clr = 1'b0;
        compare(req);
    endtask

    task automatic send_word(input bit [7:0] v, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i], 1'b0, req);
    endtask

    task automatic host_clear(input string req);
        @(negedge clk); vld_clr = 1'b1;
        @(negedge clk); vld_clr = 1'b0;
        m_valid = 0; m_age = 0;
        compare(req);
    endtask

    task automatic write_en(input bit v, input string req);
        @(negedge clk); en_we = 1'b1; en_wdata = v;
        @(negedge clk); en_we = 1'b0;
        if (!v) model_flush();
        else begin
            m_en = 1;
            if (!m_shift) m_hunt = 1;
        end
        compare(req);
    endtask

    task automatic pulse_tx(input string req);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        if (auto_mode && !m_en && m_arm > 0) begin
            m_en = 1; m_hunt = 1; m_arm--;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd4711);
        model_flush();
        m_arm = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");

        // R2: disabled lane ignores a start bit and data
        send_bit(1'b1, 1'b0, "R2");
        send_word(8'hFF, 8, "R2");

        // R11: manual enable, then idle-level bits before the start bit (R2)
        write_en(1'b1, "R11");
        send_bit(1'b0, 1'b0, "R2");
        send_bit(1'b0, 1'b0, "R2");
        send_bit(1'b1, 1'b0, "R2");
        send_word(8'hA5, 8, "R3");
        chk("R3", "byte", int'(rx_data), 'hA5);

        // R6 clear, R5 data held
        host_clear("R6");
        chk("R5", "held", int'(rx_data), 'hA5);

        // R4: 3-bit words back to back, masked upper bits (R3)
        sample_code = 3'd3;
        send_word(8'h05, 3, "R4");
        chk("R4", "3bit", int'(rx_data), 5);
        host_clear("R6");
        send_word(8'h06, 3, "R4");
        chk("R3", "mask", int'(rx_data), 6);

        // R6: clear on the same cycle a word completes
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b1, 1'b1, "R6");
        chk("R6", "clr+word valid", int'(rx_valid), 1);

        // R7: overflow with a short frame, then sticky across a clear
        frame_len = 12'd4;
        host_clear("R7");
        send_word(8'h02, 3, "R7");
        for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0, "R7");
        chk("R7", "ovf set", int'(rx_ovf), 1);
        host_clear("R7");
        chk("R7", "ovf sticky", int'(rx_ovf), 1);

        // R10: disable clears everything; re-enable with low start polarity
        write_en(1'b0, "R10");
        chk("R10", "cleared", int'({rx_data, rx_valid, rx_ovf}), 0);
        start_pol = 1'b0;
        sample_code = 3'd0;
        frame_len = 12'd20;
        write_en(1'b1, "R11");
        send_bit(1'b1, 1'b0, "R2");
        send_bit(1'b0, 1'b0, "R2");
        send_word(8'h3C, 8, "R3");
        chk("R3", "low start", int'(rx_data), 'h3C);

        // R9/R8: arm budget of two
        write_en(1'b0, "R10");
        auto_mode = 1'b1;
        @(negedge clk); arm_load = 1'b1; arm_value = 16'd2;
        @(negedge clk); arm_load = 1'b0;
        m_arm = 2;
        pulse_tx("R9");
        chk("R8", "arm1", int'(rx_enabled), 1);
        write_en(1'b0, "R10");
        pulse_tx("R8");
        chk("R8", "arm2", int'(rx_enabled), 1);
        write_en(1'b0, "R10");
        pulse_tx("R8");
        chk("R8", "budget spent", int'(rx_enabled), 0);

        // random stream
        write_en(1'b1, "R11");
        for (int k = 0; k < 400; k++) begin
            if (k % 37 == 0) sample_code = 3'($urandom_range(0, 7));
            if (k % 90 == 0) frame_len = 12'($urandom_range(3, 24));
            send_bit(1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0), "R4");
        end
        write_en(1'b0, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule